// File: doc/BRIEF.md
# Bus Prescaler Strobe Generator

This block derives five clock-enable strobes from a single fast system clock: one for the main high-speed bus, one each for two peripheral buses, and one each for the timer groups that sit on those two peripheral buses. No derived clock is produced. Every consumer stays on the system clock and advances only in cycles where its strobe is high. Each strobe is a single-cycle pulse that repeats every 2^shift system cycles. The shift comes from an encoded prescaler field.

The main-bus field is 4 bits wide and uses a non-linear code with no divide-by-32. Each peripheral-bus field is 3 bits wide. Both peripheral ratios apply to the system clock directly, not on top of the main-bus ratio. A timer-mode input sets how fast each timer strobe runs compared with its own peripheral bus:
- With the mode clear, a timer strobe runs at twice its bus rate.
- With the mode set, it runs at four times its bus rate.
- When the bus is only lightly divided, the timer strobe is pinned to the system rate (mode clear) or to the main-bus rate (mode set).

The decoded bus shifts are brought out so that software can read them back. A new prescaler setting is taken up only when a strobe fires, so a change never produces a short interval.

Top module: `busclk_strobe_gen`

## Requirements
- R1: The main-bus shift readout is 0 for codes 0 to 7. For codes 8, 9, 10, 11, 12, 13, 14 and 15 it is 1, 2, 3, 4, 6, 7, 8 and 9, so a shift of 5 never occurs. The readout follows the code in the same cycle.
- R2: Each peripheral-bus shift readout is 0 for codes 0 to 3, and 1, 2, 3 or 4 for codes 4, 5, 6 or 7. Each readout depends only on its own field and follows it in the same cycle.
- R3: With settings held, each bus strobe is high for exactly one cycle out of every 2^shift system cycles. A peripheral strobe's period depends only on its own code and not on the main-bus code.
- R4: With the timer mode low, a timer strobe fires every cycle when its peripheral shift is 0. Otherwise it fires every 2^(peripheral shift − 1) cycles.
- R5: With the timer mode high, a timer strobe fires every 2^(main-bus shift) cycles when its peripheral shift is 0, 1 or 2. Otherwise it fires every 2^(peripheral shift − 2) cycles.
- R6: The interval that follows a strobe is 2^(the shift in force in that strobe's cycle). A change of code or mode never shortens or stretches the interval already running. A change made in the very cycle of a strobe governs the interval that follows it.
- R7: While reset is high, all five strobes are low. In the first cycle after reset is released, all five are high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ahb_code | input | 4 | Main-bus prescaler code |
| apb1_code | input | 3 | First peripheral-bus prescaler code |
| apb2_code | input | 3 | Second peripheral-bus prescaler code |
| tim_x4_mode | input | 1 | Timer-rate mode (0: twice bus rate, 1: four times bus rate) |
| ahb_stb | output | 1 | Main-bus clock-enable strobe |
| apb1_stb | output | 1 | First peripheral-bus strobe |
| apb2_stb | output | 1 | Second peripheral-bus strobe |
| tim1_stb | output | 1 | Timer strobe for the first peripheral bus |
| tim2_stb | output | 1 | Timer strobe for the second peripheral bus |
| ahb_shift | output | 4 | Decoded main-bus shift |
| apb1_shift | output | 4 | Decoded first peripheral-bus shift |
| apb2_shift | output | 4 | Decoded second peripheral-bus shift |

## Verification
A prescaler update and a terminal count can land in the same cycle, and that overlap is the case that decides whether runt or stretched intervals exist. To provoke it, the bench changes every code and the mode on exactly the cycle where a period-4 strobe fires. It expects the new periods to start from that strobe, with the next main-bus strobe 16 cycles later. A second run changes the settings mid-interval and expects the old interval to complete first. Expected strobe patterns come from a closed-form rule: the first strobe at or after the change point ends the old spacing, and the new spacing starts there.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int BCS_AHB_W     = 4;
    localparam int BCS_APB_W     = 3;
    localparam int BCS_SHIFT_W   = 4;
    localparam int BCS_MAX_SHIFT = 9;
    localparam int BCS_N_CH      = 5;

    // strobe channel slots
    localparam int CH_AHB  = 0;
    localparam int CH_APB1 = 1;
    localparam int CH_APB2 = 2;
    localparam int CH_TIM1 = 3;
    localparam int CH_TIM2 = 4;

    typedef logic [BCS_SHIFT_W-1:0] bcs_shift_t;

    typedef struct packed {
        bcs_shift_t ahb;
        bcs_shift_t apb1;
        bcs_shift_t apb2;
        bcs_shift_t tim1;
        bcs_shift_t tim2;
    } bcs_shifts_t;

    // main-bus code: upper half maps to 1,2,3,4,6,7,8,9 (5 skipped)
    function automatic bcs_shift_t ahb_shift_of(input logic [BCS_AHB_W-1:0] code);
        logic [BCS_AHB_W-2:0] idx;
        idx = code[BCS_AHB_W-2:0];
        if (!code[BCS_AHB_W-1])
            return '0;
        else if (idx < (BCS_AHB_W-1)'(4))
            return BCS_SHIFT_W'(idx) + BCS_SHIFT_W'(1);
        else
            return BCS_SHIFT_W'(idx) + BCS_SHIFT_W'(2);
    endfunction

    // peripheral-bus code: upper half maps to 1..4
    function automatic bcs_shift_t apb_shift_of(input logic [BCS_APB_W-1:0] code);
        if (!code[BCS_APB_W-1])
            return '0;
        else
            return BCS_SHIFT_W'(code[BCS_APB_W-2:0]) + BCS_SHIFT_W'(1);
    endfunction

    // timer shift from mode, its bus shift and the main-bus shift
    function automatic bcs_shift_t tim_shift_of(input logic x4_mode,
                                                input bcs_shift_t bus_sh,
                                                input bcs_shift_t ahb_sh);
        if (!x4_mode) begin
            if (bus_sh == '0)
                return '0;
            else
                return bus_sh - BCS_SHIFT_W'(1);
        end else begin
            if (bus_sh <= BCS_SHIFT_W'(2))
                return ahb_sh;
            else
                return bus_sh - BCS_SHIFT_W'(2);
        end
    endfunction

endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
    import bcs_pkg::*;
(
    input  logic [BCS_AHB_W-1:0] ahb_code,
    input  logic [BCS_APB_W-1:0] apb1_code,
    input  logic [BCS_APB_W-1:0] apb2_code,
    input  logic                 tim_x4_mode,
    output bcs_shifts_t          shifts
);

    always_comb begin
        shifts.ahb  = ahb_shift_of(ahb_code);
        shifts.apb1 = apb_shift_of(apb1_code);
        shifts.apb2 = apb_shift_of(apb2_code);
        shifts.tim1 = tim_shift_of(tim_x4_mode, shifts.apb1, shifts.ahb);
        shifts.tim2 = tim_shift_of(tim_x4_mode, shifts.apb2, shifts.ahb);
    end

endmodule

// File: rtl/bcs_divider.sv
module bcs_divider #(
    parameter int SHIFT_W = 4,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SHIFT_W-1:0] shift_req,
    output logic               strobe
);

    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] sh_eff;
    logic [SPAN_W-1:0]  span;
    logic [CNT_W-1:0]   reload;
    logic               at_term;

    // clamp to the counter reach, then reload value is 2^shift - 1
    always_comb begin
        sh_eff  = (shift_req > SHIFT_W'(CNT_W)) ? SHIFT_W'(CNT_W) : shift_req;
        span    = SPAN_W'(1) << sh_eff;
        reload  = CNT_W'(span - SPAN_W'(1));
        at_term = (cnt == '0);
    end

    // new shift is sampled only at the terminal count
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (at_term)
            cnt <= reload;
        else
            cnt <= cnt - CNT_W'(1);
    end

    assign strobe = at_term & ~rst;

endmodule

// File: rtl/busclk_strobe_gen.sv
module busclk_strobe_gen
    import bcs_pkg::*;
#(
    parameter int MAX_SHIFT = BCS_MAX_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BCS_AHB_W-1:0]   ahb_code,
    input  logic [BCS_APB_W-1:0]   apb1_code,
    input  logic [BCS_APB_W-1:0]   apb2_code,
    input  logic                   tim_x4_mode,
    output logic                   ahb_stb,
    output logic                   apb1_stb,
    output logic                   apb2_stb,
    output logic                   tim1_stb,
    output logic                   tim2_stb,
    output logic [BCS_SHIFT_W-1:0] ahb_shift,
    output logic [BCS_SHIFT_W-1:0] apb1_shift,
    output logic [BCS_SHIFT_W-1:0] apb2_shift
);

    localparam int CNT_W = MAX_SHIFT;

    bcs_shifts_t                          shifts;
    logic [BCS_N_CH-1:0][BCS_SHIFT_W-1:0] ch_shift;
    logic [BCS_N_CH-1:0]                  ch_stb;

    bcs_decode u_decode (
        .ahb_code    (ahb_code),
        .apb1_code   (apb1_code),
        .apb2_code   (apb2_code),
        .tim_x4_mode (tim_x4_mode),
        .shifts      (shifts)
    );

    always_comb begin
        ch_shift[CH_AHB]  = shifts.ahb;
        ch_shift[CH_APB1] = shifts.apb1;
        ch_shift[CH_APB2] = shifts.apb2;
        ch_shift[CH_TIM1] = shifts.tim1;
        ch_shift[CH_TIM2] = shifts.tim2;
    end

    for (genvar g = 0; g < BCS_N_CH; g++) begin : g_chan
        bcs_divider #(
            .SHIFT_W (BCS_SHIFT_W),
            .CNT_W   (CNT_W)
        ) u_div (
            .clk       (clk),
            .rst       (rst),
            .shift_req (ch_shift[g]),
            .strobe    (ch_stb[g])
        );
    end

    assign ahb_stb    = ch_stb[CH_AHB];
    assign apb1_stb   = ch_stb[CH_APB1];
    assign apb2_stb   = ch_stb[CH_APB2];
    assign tim1_stb   = ch_stb[CH_TIM1];
    assign tim2_stb   = ch_stb[CH_TIM2];
    assign ahb_shift  = shifts.ahb;
    assign apb1_shift = shifts.apb1;
    assign apb2_shift = shifts.apb2;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ahb_code,
    input logic [2:0] apb1_code,
    input logic [3:0] ahb_shift,
    input logic [3:0] apb1_shift,
    input logic       ahb_stb,
    input logic       apb1_stb,
    input logic       apb2_stb,
    input logic       tim1_stb,
    input logic       tim2_stb
);

    logic [10:0] gap_a, gap_p;
    logic [3:0]  held_a, held_p;
    logic        seen_a, seen_p;

    // interval trackers for R6
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_a  <= '0;
            gap_p  <= '0;
            held_a <= '0;
            held_p <= '0;
            seen_a <= 1'b0;
            seen_p <= 1'b0;
        end else begin
            gap_a  <= ahb_stb  ? 11'd1 : gap_a + 11'd1;
            gap_p  <= apb1_stb ? 11'd1 : gap_p + 11'd1;
            held_a <= ahb_stb  ? ahb_shift  : held_a;
            held_p <= apb1_stb ? apb1_shift : held_p;
            seen_a <= seen_a | ahb_stb;
            seen_p <= seen_p | apb1_stb;
        end
    end

    a_r1_low_codes: assert property (@(posedge clk) disable iff (rst)
        !ahb_code[3] |-> ahb_shift == 4'd0);

    a_r1_no_div32: assert property (@(posedge clk) disable iff (rst)
        ahb_shift != 4'd5);

    a_r2_low_codes: assert property (@(posedge clk) disable iff (rst)
        !apb1_code[2] |-> apb1_shift == 4'd0);

    a_r3_full_rate: assert property (@(posedge clk) disable iff (rst)
        ($past(ahb_stb) && $past(ahb_shift) == 4'd0) |-> ahb_stb);

    a_r6_ahb_gap: assert property (@(posedge clk) disable iff (rst)
        (ahb_stb && seen_a) |-> gap_a == (11'd1 << held_a));

    a_r6_apb1_gap: assert property (@(posedge clk) disable iff (rst)
        (apb1_stb && seen_p) |-> gap_p == (11'd1 << held_p));

    a_r7_first: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ahb_stb && apb1_stb && apb2_stb && tim1_stb && tim2_stb));

    a_r7_quiet: assert property (@(posedge clk)
        rst |-> !(ahb_stb || apb1_stb || apb2_stb || tim1_stb || tim2_stb));

endmodule

bind busclk_strobe_gen bcs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ahb_code   (ahb_code),
    .apb1_code  (apb1_code),
    .ahb_shift  (ahb_shift),
    .apb1_shift (apb1_shift),
    .ahb_stb    (ahb_stb),
    .apb1_stb   (apb1_stb),
    .apb2_stb   (apb2_stb),
    .tim1_stb   (tim1_stb),
    .tim2_stb   (tim2_stb)
);

// File: tb/busclk_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module busclk_strobe_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = CLK_PERIOD * 3 / 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ahb_code = '0;
    logic [2:0] apb1_code = '0;
    logic [2:0] apb2_code = '0;
    logic       tim_x4_mode = 1'b0;
    logic       ahb_stb, apb1_stb, apb2_stb, tim1_stb, tim2_stb;
    logic [3:0] ahb_shift, apb1_shift, apb2_shift;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int ahb;
        int apb1;
        int apb2;
        int mode;
    } cfg_t;

    typedef struct {
        logic [4:0] vec;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    busclk_strobe_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .ahb_code    (ahb_code),
        .apb1_code   (apb1_code),
        .apb2_code   (apb2_code),
        .tim_x4_mode (tim_x4_mode),
        .ahb_stb     (ahb_stb),
        .apb1_stb    (apb1_stb),
        .apb2_stb    (apb2_stb),
        .tim1_stb    (tim1_stb),
        .tim2_stb    (tim2_stb),
        .ahb_shift   (ahb_shift),
        .apb1_shift  (apb1_shift),
        .apb2_shift  (apb2_shift)
    );

    // expected shifts, straight from R1/R2/R4/R5
    function automatic int ref_ahb(int code);
        int tbl[8] = '{1, 2, 3, 4, 6, 7, 8, 9};
        if (code < 8) return 0;
        return tbl[code - 8];
    endfunction

    function automatic int ref_apb(int code);
        return (code < 4) ? 0 : code - 3;
    endfunction

    function automatic int ref_tim(int mode, int bus, int ahb);
        if (mode == 0) return (bus == 0) ? 0 : bus - 1;
        return (bus <= 2) ? ahb : bus - 2;
    endfunction

    function automatic int period_of(cfg_t c, int ch);
        int a, p1, p2, sh;
        a  = ref_ahb(c.ahb);
        p1 = ref_apb(c.apb1);
        p2 = ref_apb(c.apb2);
        case (ch)
            0:       sh = a;
            1:       sh = p1;
            2:       sh = p2;
            3:       sh = ref_tim(c.mode, p1, a);
            default: sh = ref_tim(c.mode, p2, a);
        endcase
        return 1 << sh;
    endfunction

    // old spacing until first strobe at or after j, new spacing from there
    function automatic bit pulse_at(int k, int pa, int pb, int j);
        int first;
        if (k < j) return (k % pa) == 0;
        first = ((j + pa - 1) / pa) * pa;
        if (k < first) return 1'b0;
        return ((k - first) % pb) == 0;
    endfunction

    function automatic logic [4:0] exp_vec(int k, cfg_t a, cfg_t b, int j);
        logic [4:0] v;
        for (int ch = 0; ch < 5; ch++)
            v[ch] = pulse_at(k, period_of(a, ch), period_of(b, ch), j);
        return v;
    endfunction

    task automatic apply(cfg_t c);
        ahb_code    = 4'(c.ahb);
        apb1_code   = 3'(c.apb1);
        apb2_code   = 3'(c.apb2);
        tim_x4_mode = c.mode[0];
    endtask

    task automatic check(bit ok, string tag, string what, int got, int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
        end
    endtask

    // driver: reset, queue the expected strobe vectors, release, change at j
    task automatic run_seq(cfg_t a, cfg_t b, int j, int n, string tag);
        @(negedge clk);
        rst = 1'b1;
        apply(a);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.vec = exp_vec(k, a, b, j);
            e.cyc = k;
            e.tag = tag;
            exp_q.push_back(e);
        end
        rst = 1'b0;
        #1;
        check(ahb_shift == 4'(ref_ahb(a.ahb)), "R1", "ahb_shift readback",
              int'(ahb_shift), ref_ahb(a.ahb));
        check(apb1_shift == 4'(ref_apb(a.apb1)), "R2", "apb1_shift readback",
              int'(apb1_shift), ref_apb(a.apb1));
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k + 1 == j) apply(b);
        end
    endtask

    // monitor: pop and compare just before each consuming edge
    initial begin
        forever begin
            @(posedge clk);
            #(SAMPLE_DLY);
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                e   = exp_q.pop_front();
                got = {tim2_stb, tim1_stb, apb2_stb, apb1_stb, ahb_stb};
                checks++;
                if (got !== e.vec) begin
                    errors++;
                    $display("FAIL %s cycle %0d strobes: got %b expected %b",
                             e.tag, e.cyc, got, e.vec);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        cfg_t c0, c1, c2, c3, c4, ca, cb, cc, cd;

        // R7: all strobes quiet while reset is held
        c1 = '{15, 7, 7, 1};
        apply(c1);
        repeat (3) @(posedge clk);
        #(SAMPLE_DLY);
        check({tim2_stb, tim1_stb, apb2_stb, apb1_stb, ahb_stb} == 5'b0, "R7",
              "strobes in reset", int'({tim2_stb, tim1_stb, apb2_stb, apb1_stb, ahb_stb}), 0);

        // R1 and R2: full decode sweep of the readouts
        for (int code = 0; code < 16; code++) begin
            @(negedge clk);
            ahb_code  = 4'(code);
            apb1_code = 3'(code % 8);
            apb2_code = 3'(7 - (code % 8));
            #1;
            check(ahb_shift == 4'(ref_ahb(code)), "R1", "ahb decode",
                  int'(ahb_shift), ref_ahb(code));
            check(apb1_shift == 4'(ref_apb(code % 8)), "R2", "apb1 decode",
                  int'(apb1_shift), ref_apb(code % 8));
            check(apb2_shift == 4'(ref_apb(7 - (code % 8))), "R2", "apb2 decode",
                  int'(apb2_shift), ref_apb(7 - (code % 8)));
        end

        // R3 R4 R7: undivided, every strobe every cycle
        c0 = '{0, 0, 0, 0};
        run_seq(c0, c0, 1 << 20, 8, "R3/R4/R7");

        // R3 R4: deepest main-bus divide plus mixed peripheral divides
        c1 = '{15, 7, 5, 0};
        run_seq(c1, c1, 1 << 20, 1030, "R3/R4");

        // R4: peripheral shift 1 gives timer every cycle
        c2 = '{0, 4, 0, 0};
        run_seq(c2, c2, 1 << 20, 10, "R4");

        // R5: mode high, one timer tied to main bus, one at four times bus
        c3 = '{10, 6, 5, 1};
        run_seq(c3, c3, 1 << 20, 40, "R5");

        // R5: mode high, both buses lightly divided, timers follow main bus
        c4 = '{12, 4, 3, 1};
        run_seq(c4, c4, 1 << 20, 140, "R5/R3");

        // R6: change in mid-interval; old spacing completes first
        ca = '{9, 5, 0, 0};
        cb = '{8, 7, 6, 1};
        run_seq(ca, cb, 5, 60, "R6");

        // R6: change on the very cycle of a period-4 strobe
        cc = '{9, 4, 1, 0};
        cd = '{11, 0, 7, 1};
        run_seq(cc, cd, 4, 40, "R6");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule